// File: doc/BRIEF.md
# Interrupt Response Sequencer

This block lives in the timing unit of an 8-bit processor core. At the final clock of every instruction it looks at a maskable request line and a latched non-maskable request. It picks at most one of them and then runs the bus cycle that acknowledges it. The core signals that final clock with `instr_end`.

A maskable acknowledge is an opcode-fetch cycle that raises the I/O strobe in place of the memory strobe. It gets two extra wait clocks, so that a chain of prioritised peripherals can settle. It closes by latching the 8-bit vector the device places on the data bus. A non-maskable acknowledge looks like a plain memory read whose data is thrown away. It ends with a request to push the program counter and load the fixed restart address `16'h0066`.

The block also owns the two interrupt-enable flip-flops and the halt state. If a qualifying request is accepted while the core is halted, the halt state is left one clock later. The acknowledge cycle follows straight after.

Top module: `irq_resp_seq`

## Requirements
- R1: After synchronous reset all strobes (`m1_n`, `mreq_n`, `iorq_n`, `rd_n`) are high, `ie1`, `ie2`, `halt_o`, `vec_valid` and `push_req` are 0, and no non-maskable request is pending.
- R2: Requests are only taken on a clock edge where `instr_end` is 1 and no acknowledge cycle is running. Requests held without `instr_end` leave every strobe high.
- R3: When a non-maskable request is pending and `int_req` is 1 at the same sample, the non-maskable acknowledge is run.
- R4: A pending non-maskable request is accepted whatever the state of `ie1`. `int_req` is accepted only while `ie1` is 1.
- R5: Maskable acknowledge, counting clocks after the accepting edge as 1, 2, …: `m1_n` is low in clocks 1–4, `iorq_n` is low in clocks 3–4, and `mreq_n` and `rd_n` stay high.
- R6: The vector is taken from `data_in` at the edge that ends clock 4. It appears on `vec_o` with a one-clock `vec_valid` pulse in clock 5.
- R7: Non-maskable acknowledge: `m1_n`, `mreq_n` and `rd_n` are low in clocks 1–2 and `iorq_n` stays high. In clock 3, `push_req` and `pc_load` are 1 and `new_pc` is `16'h0066`. `vec_o` is not changed.
- R8: A maskable accept clears `ie1` and `ie2`. A non-maskable accept copies `ie1` into `ie2` and then clears `ie1`. `ie_set` sets both, `ie_clr` clears both, and `ie_restore` copies `ie2` into `ie1`.
- R9: A falling edge on `nmi_n` produces exactly one non-maskable accept, even if the line is held low.
- R10: A `halt_req` pulse while idle sets `halt_o`. On an accept while halted, clock 1 keeps `halt_o` at 1 with all strobes high. `halt_o` drops in clock 2, and the acknowledge sequence of R5/R7 is then shifted one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_end | input | 1 | Last clock of the current instruction (sampling point) |
| int_req | input | 1 | Maskable request, active high, level |
| nmi_n | input | 1 | Non-maskable request, active low, edge-detected |
| ie_set | input | 1 | Enable-interrupts pulse from decode |
| ie_clr | input | 1 | Disable-interrupts pulse from decode |
| ie_restore | input | 1 | Copy saved enable back into `ie1` |
| halt_req | input | 1 | Core executed a halt instruction |
| data_in | input | 8 | Data bus input |
| m1_n | output | 1 | Opcode-fetch strobe, active low |
| mreq_n | output | 1 | Memory request strobe, active low |
| iorq_n | output | 1 | I/O request strobe, active low |
| rd_n | output | 1 | Read strobe, active low |
| vec_o | output | 8 | Latched maskable vector |
| vec_valid | output | 1 | One-clock pulse when `vec_o` is updated |
| push_req | output | 1 | Request to push the program counter |
| pc_load | output | 1 | Request to load `new_pc` into the program counter |
| new_pc | output | 16 | Restart address, valid with `pc_load` |
| ie1 | output | 1 | Interrupt enable flip-flop |
| ie2 | output | 1 | Saved enable flip-flop |
| halt_o | output | 1 | Halt state |

## Verification
Every result is timed from the accepting edge. For a maskable accept, the strobes are due in clocks 1–4 after that edge and the vector in clock 5. For a non-maskable accept, the strobes are due in clocks 1–2 and the push and restart address in clock 3. When the core was halted, each of these is one clock later. The bench drives inputs on the falling clock edge and reads outputs one time unit after each rising edge. In each of eight clocks following a sample it compares all strobes, pulses and `halt_o` with a table computed from the accept kind and halt flag. The enable flip-flops and `vec_o` are compared against a bench model after the sequence ends.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_EXIT,
        SQ_IA_T1,
        SQ_IA_T2,
        SQ_IA_TW,
        SQ_IA_T3,
        SQ_NM_T1,
        SQ_NM_T2,
        SQ_NM_T3
    } seq_state_e;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_MASK,
        ACC_NMI
    } accept_e;

    typedef struct packed {
        logic m1_n;
        logic mreq_n;
        logic iorq_n;
        logic rd_n;
    } bus_strb_t;

    localparam bus_strb_t STRB_IDLE = '{m1_n: 1'b1, mreq_n: 1'b1, iorq_n: 1'b1, rd_n: 1'b1};

    function automatic bus_strb_t strobes_for(input seq_state_e st);
        bus_strb_t s;
        s = STRB_IDLE;
        case (st)
            SQ_IA_T1, SQ_IA_T2: s.m1_n = 1'b0;
            SQ_IA_TW: begin
                s.m1_n   = 1'b0;
                s.iorq_n = 1'b0;
            end
            SQ_NM_T1, SQ_NM_T2: begin
                s.m1_n   = 1'b0;
                s.mreq_n = 1'b0;
                s.rd_n   = 1'b0;
            end
            default: s = STRB_IDLE;
        endcase
        return s;
    endfunction

    function automatic seq_state_e first_state(input accept_e k);
        return (k == ACC_NMI) ? SQ_NM_T1 : SQ_IA_T1;
    endfunction

endpackage

// File: rtl/irq_nmi_latch.sv
module irq_nmi_latch (
    input  logic clk,
    input  logic rst,
    input  logic nmi_n,
    input  logic take,
    output logic pend
);
    logic prev_q;
    logic fall;

    assign fall = prev_q & ~nmi_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b1;
            pend   <= 1'b0;
        end else begin
            prev_q <= nmi_n;
            pend   <= fall | (pend & ~take);
        end
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_seq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    instr_end,
    input  logic    idle,
    input  logic    int_req,
    input  logic    nmi_pend,
    input  logic    ie_set,
    input  logic    ie_clr,
    input  logic    ie_restore,
    output accept_e kind,
    output logic    ie1,
    output logic    ie2
);
    logic sample;

    assign sample = instr_end & idle;

    always_comb begin
        kind = ACC_NONE;
        if (sample) begin
            if (nmi_pend)
                kind = ACC_NMI;
            else if (int_req && ie1)
                kind = ACC_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ie1 <= 1'b0;
            ie2 <= 1'b0;
        end else begin
            unique case (kind)
                ACC_NMI: begin
                    ie2 <= ie1;
                    ie1 <= 1'b0;
                end
                ACC_MASK: begin
                    ie1 <= 1'b0;
                    ie2 <= 1'b0;
                end
                default: begin
                    if (ie_set) begin
                        ie1 <= 1'b1;
                        ie2 <= 1'b1;
                    end else if (ie_clr) begin
                        ie1 <= 1'b0;
                        ie2 <= 1'b0;
                    end else if (ie_restore) begin
                        ie1 <= ie2;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/irq_ack_fsm.sv
module irq_ack_fsm
    import irq_seq_pkg::*;
#(
    parameter int VEC_W      = 8,
    parameter int ACK_WAITS  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  accept_e          kind,
    input  logic             halt_req,
    input  logic [VEC_W-1:0] data_in,
    output bus_strb_t        strb,
    output logic             idle,
    output logic             halt_o,
    output logic [VEC_W-1:0] vec_o,
    output logic             vec_valid,
    output logic             nmi_done
);
    localparam int CW = $clog2(ACK_WAITS + 1);
    localparam logic [CW-1:0] LAST_W = CW'(ACK_WAITS - 1);

    seq_state_e state;
    accept_e    held_kind;
    logic [CW-1:0] wcnt;

    assign strb      = strobes_for(state);
    assign idle      = (state == SQ_IDLE);
    assign vec_valid = (state == SQ_IA_T3);
    assign nmi_done  = (state == SQ_NM_T3);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SQ_IDLE;
            held_kind <= ACC_NONE;
            wcnt      <= '0;
            halt_o    <= 1'b0;
            vec_o     <= '0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (kind != ACC_NONE) begin
                        held_kind <= kind;
                        state     <= halt_o ? SQ_EXIT : first_state(kind);
                    end else if (halt_req) begin
                        halt_o <= 1'b1;
                    end
                end
                SQ_EXIT: begin
                    halt_o <= 1'b0;
                    state  <= first_state(held_kind);
                end
                SQ_IA_T1: state <= SQ_IA_T2;
                SQ_IA_T2: begin
                    wcnt  <= '0;
                    state <= SQ_IA_TW;
                end
                SQ_IA_TW: begin
                    if (wcnt == LAST_W) begin
                        vec_o <= data_in;
                        state <= SQ_IA_T3;
                    end else begin
                        wcnt <= wcnt + 1'b1;
                    end
                end
                SQ_NM_T1: state <= SQ_NM_T2;
                SQ_NM_T2: state <= SQ_NM_T3;
                default:  state <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/irq_resp_seq.sv
module irq_resp_seq
    import irq_seq_pkg::*;
#(
    parameter int          VEC_W     = 8,
    parameter int          PC_W      = 16,
    parameter int          ACK_WAITS = 2,
    parameter logic [15:0] NMI_ADDR  = 16'h0066
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             instr_end,
    input  logic             int_req,
    input  logic             nmi_n,
    input  logic             ie_set,
    input  logic             ie_clr,
    input  logic             ie_restore,
    input  logic             halt_req,
    input  logic [VEC_W-1:0] data_in,
    output logic             m1_n,
    output logic             mreq_n,
    output logic             iorq_n,
    output logic             rd_n,
    output logic [VEC_W-1:0] vec_o,
    output logic             vec_valid,
    output logic             push_req,
    output logic             pc_load,
    output logic [PC_W-1:0]  new_pc,
    output logic             ie1,
    output logic             ie2,
    output logic             halt_o
);
    accept_e   kind;
    logic      nmi_pend;
    logic      idle;
    logic      nmi_done;
    bus_strb_t strb;

    irq_nmi_latch u_nmi (
        .clk  (clk),
        .rst  (rst),
        .nmi_n(nmi_n),
        .take (kind == ACC_NMI),
        .pend (nmi_pend)
    );

    irq_arbiter u_arb (
        .clk       (clk),
        .rst       (rst),
        .instr_end (instr_end),
        .idle      (idle),
        .int_req   (int_req),
        .nmi_pend  (nmi_pend),
        .ie_set    (ie_set),
        .ie_clr    (ie_clr),
        .ie_restore(ie_restore),
        .kind      (kind),
        .ie1       (ie1),
        .ie2       (ie2)
    );

    irq_ack_fsm #(
        .VEC_W    (VEC_W),
        .ACK_WAITS(ACK_WAITS)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .kind     (kind),
        .halt_req (halt_req),
        .data_in  (data_in),
        .strb     (strb),
        .idle     (idle),
        .halt_o   (halt_o),
        .vec_o    (vec_o),
        .vec_valid(vec_valid),
        .nmi_done (nmi_done)
    );

    assign m1_n     = strb.m1_n;
    assign mreq_n   = strb.mreq_n;
    assign iorq_n   = strb.iorq_n;
    assign rd_n     = strb.rd_n;
    assign push_req = nmi_done;
    assign pc_load  = nmi_done;
    assign new_pc   = nmi_done ? PC_W'(NMI_ADDR) : '0;
endmodule

// File: rtl/irq_resp_seq_chk.sv
module irq_resp_seq_chk #(
    parameter int VEC_W = 8,
    parameter int PC_W  = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [VEC_W-1:0] data_in,
    input logic             m1_n,
    input logic             mreq_n,
    input logic             iorq_n,
    input logic             rd_n,
    input logic [VEC_W-1:0] vec_o,
    input logic             vec_valid,
    input logic             push_req,
    input logic [PC_W-1:0]  new_pc,
    input logic             halt_o
);
    // R5: the I/O strobe only appears inside an opcode-fetch acknowledge, never with the memory strobe
    assert_iorq_in_ack_R5: assert property (@(posedge clk) disable iff (rst)
        !iorq_n |-> (!m1_n && mreq_n && rd_n));

    // R6: presented vector equals the bus value at the capturing edge
    assert_vec_capture_R6: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> (vec_o == $past(data_in)));

    // R7: push request follows a memory-read style clock and carries the restart address
    assert_nmi_push_R7: assert property (@(posedge clk) disable iff (rst)
        push_req |-> ($past(!mreq_n && !rd_n && iorq_n) && new_pc == PC_W'(16'h0066)));

    // R7: the non-maskable path never changes the vector register
    assert_nmi_keeps_vec_R7: assert property (@(posedge clk) disable iff (rst)
        push_req |-> $stable(vec_o));

    // R10: leaving halt coincides with the start of an acknowledge
    assert_halt_exit_R10: assert property (@(posedge clk) disable iff (rst)
        ($fell(halt_o) && !$past(rst)) |-> !m1_n);
endmodule

bind irq_resp_seq irq_resp_seq_chk #(.VEC_W(VEC_W), .PC_W(PC_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .data_in  (data_in),
    .m1_n     (m1_n),
    .mreq_n   (mreq_n),
    .iorq_n   (iorq_n),
    .rd_n     (rd_n),
    .vec_o    (vec_o),
    .vec_valid(vec_valid),
    .push_req (push_req),
    .new_pc   (new_pc),
    .halt_o   (halt_o)
);

// File: tb/sim_irq_resp_seq.sv
module sim_irq_resp_seq;
    localparam int CLK_PERIOD = 10;
    localparam int K_NONE = 0, K_MASK = 1, K_NMI = 2;

    logic clk = 1'b0;
    logic rst, instr_end, int_req, nmi_n, ie_set, ie_clr, ie_restore, halt_req;
    logic [7:0] data_in;
    logic m1_n, mreq_n, iorq_n, rd_n, vec_valid, push_req, pc_load, ie1, ie2, halt_o;
    logic [7:0] vec_o;
    logic [15:0] new_pc;

    int checks = 0;
    int failures = 0;
    bit m_ie1, m_ie2, m_pend, m_halt;
    logic [7:0] m_vec;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_resp_seq u0 (
        .clk(clk), .rst(rst), .instr_end(instr_end), .int_req(int_req), .nmi_n(nmi_n),
        .ie_set(ie_set), .ie_clr(ie_clr), .ie_restore(ie_restore), .halt_req(halt_req),
        .data_in(data_in), .m1_n(m1_n), .mreq_n(mreq_n), .iorq_n(iorq_n), .rd_n(rd_n),
        .vec_o(vec_o), .vec_valid(vec_valid), .push_req(push_req), .pc_load(pc_load),
        .new_pc(new_pc), .ie1(ie1), .ie2(ie2), .halt_o(halt_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // bits: m1_n mreq_n iorq_n rd_n vec_valid push pc_load halt
    function automatic logic [7:0] exp_bus(input int kind, input bit h, input int k);
        logic [7:0] e;
        int j;
        e = 8'b1111_0000;
        j = (h && kind != K_NONE) ? k - 1 : k;
        if (kind == K_MASK) begin
            if (j >= 1 && j <= 4) e[7] = 1'b0;
            if (j >= 3 && j <= 4) e[5] = 1'b0;
            if (j == 5) e[3] = 1'b1;
        end else if (kind == K_NMI) begin
            if (j >= 1 && j <= 2) begin e[7] = 1'b0; e[6] = 1'b0; e[4] = 1'b0; end
            if (j == 3) begin e[2] = 1'b1; e[1] = 1'b1; end
        end
        if (h) e[0] = (kind == K_NONE) ? 1'b1 : (k == 1);
        return e;
    endfunction

    function automatic int predict_kind();
        if (m_pend) return K_NMI;
        if (int_req && m_ie1) return K_MASK;
        return K_NONE;
    endfunction

    task automatic do_sample(input string req);
        int kind;
        bit h;
        kind = predict_kind();
        h = m_halt;
        @(negedge clk) instr_end = 1'b1;
        @(posedge clk); #1;
        for (int k = 1; k <= 8; k++) begin
            chk(req, {m1_n, mreq_n, iorq_n, rd_n, vec_valid, push_req, pc_load, halt_o},
                exp_bus(kind, h, k));
            if (push_req) chk({req, " R7 new_pc"}, new_pc, 16'h0066);
            @(negedge clk) instr_end = 1'b0;
            @(posedge clk); #1;
        end
        if (kind == K_MASK) begin
            m_vec = data_in; m_ie1 = 0; m_ie2 = 0;
        end else if (kind == K_NMI) begin
            m_ie2 = m_ie1; m_ie1 = 0; m_pend = 0;
        end
        if (kind != K_NONE) m_halt = 0;
        chk({req, " R6/R7 vec_o"}, vec_o, m_vec);
        chk({req, " R8 ie1"}, ie1, m_ie1);
        chk({req, " R8 ie2"}, ie2, m_ie2);
    endtask

    task automatic pulse_nmi();
        @(negedge clk) nmi_n = 1'b0;
        @(negedge clk) nmi_n = 1'b1;
        m_pend = 1;
    endtask

    task automatic ie_op(input int op);
        @(negedge clk);
        ie_set = (op == 1); ie_clr = (op == 2); ie_restore = (op == 3);
        @(negedge clk);
        ie_set = 0; ie_clr = 0; ie_restore = 0;
        if (op == 1) begin m_ie1 = 1; m_ie2 = 1; end
        else if (op == 2) begin m_ie1 = 0; m_ie2 = 0; end
        else if (op == 3) m_ie1 = m_ie2;
    endtask

    task automatic go_halt();
        @(negedge clk) halt_req = 1'b1;
        @(negedge clk) halt_req = 1'b0;
        m_halt = 1;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int dummy;
        dummy = $urandom(32'd1234);
        rst = 1; instr_end = 0; int_req = 0; nmi_n = 1; ie_set = 0; ie_clr = 0;
        ie_restore = 0; halt_req = 0; data_in = 8'h00;
        m_ie1 = 0; m_ie2 = 0; m_pend = 0; m_halt = 0; m_vec = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;
        #1;
        chk("R1 strobes/pulses/halt", {m1_n, mreq_n, iorq_n, rd_n, vec_valid, push_req, pc_load, halt_o}, 8'hF0);
        chk("R1 ie", {ie1, ie2}, 2'b00);

        // R1/R4: no pending NMI after reset, int ignored with ie1 clear
        int_req = 1;
        do_sample("R1 R4 masked int ignored");

        // R2: requests without instr_end do nothing
        ie_op(1);
        pulse_nmi();
        for (int i = 0; i < 6; i++) begin
            @(posedge clk); #1;
            chk("R2 no sample without instr_end", {m1_n, mreq_n, iorq_n, rd_n}, 4'hF);
        end
        // R3: both present -> NMI; R8 copy of ie1
        data_in = 8'h5A;
        do_sample("R3 nmi wins");
        ie_op(3);
        chk("R8 restore", ie1, 1'b1);
        data_in = 8'hC3;
        do_sample("R5 R6 mask ack");
        int_req = 0;

        // R4: NMI with ie1 clear; R9 held low gives one accept
        @(negedge clk) nmi_n = 1'b0;
        m_pend = 1;
        data_in = 8'h11;
        do_sample("R4 R9 nmi first");
        do_sample("R9 nmi held low no second");
        @(negedge clk) nmi_n = 1'b1;

        // R10: halt exit for both kinds
        go_halt();
        chk("R10 halt set", halt_o, 1'b1);
        do_sample("R10 halted no request");
        ie_op(1);
        int_req = 1;
        data_in = 8'h77;
        do_sample("R10 halted mask");
        int_req = 0;
        go_halt();
        pulse_nmi();
        do_sample("R10 halted nmi");

        // random mix
        for (int it = 0; it < 80; it++) begin
            int op;
            op = $urandom_range(0, 3);
            ie_op(op);
            if ($urandom_range(0, 3) == 0) pulse_nmi();
            if (!m_halt && $urandom_range(0, 3) == 0) go_halt();
            @(negedge clk);
            int_req = $urandom_range(0, 1);
            data_in = 8'($urandom);
            do_sample("R3 R4 R5 R7 R8 random");
            int_req = 0;
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule